// File: doc/BRIEF.md
# Page-Buffered Program Sequencer

This block is the write and read controller of a page-programmed non-volatile memory model. A host talks to it through three active-low strobes (chip enable, write enable, output enable), a 16-bit address and 16-bit data. The strobes are asynchronous to the block clock and are synchronised internally. A write cycle drops one word into a page buffer of 128 words. The lower seven address bits pick the word within the page, and the upper nine bits name the page. Words may be loaded in any order.

The first accepted word opens a load phase. Each further word for the same page restarts a load window of `LOAD_WIN_CYC` clock cycles. When the window runs out with no new word, the block enters a programming phase that lasts `PROG_CYC` cycles and holds `busy` high. During that phase the whole page is committed to the storage array, and every word that was not loaded is stored as all ones. A word aimed at a different page during a load phase is dropped and sets a sticky error flag. While `busy` is high, write cycles are ignored and reads return a fixed status pattern. At all other times a read returns the stored word. The output-enable indication `dout_en` stands in for driving a tri-state bus.

The model keeps `NUM_PAGES` pages of storage. The page is selected by the low bits of the page field, so page numbers repeat modulo `NUM_PAGES`.

Top module: `pgp_page_prog`

## Requirements
- R1: After reset, `busy`, `page_err` and `dout_en` are all 0.
- R2: `dout_en` is 1 only while `ce_n` and `oe_n` are both low, after the synchroniser delay. Whenever either strobe is high, `dout_en` is 0, which means the bus is released.
- R3: A write cycle counts only while `ce_n` and `we_n` are low and `oe_n` is high. With `oe_n` low, no word is loaded and no programming phase follows.
- R4: The address is taken when the write condition becomes true, which is the later of the two strobe assertions. The data is taken when the condition ends, which is the earlier of the two deassertions. Address or data values shown in between are not stored.
- R5: Each accepted word restarts the load window. `busy` rises exactly `LOAD_WIN_CYC`+1 cycles after the cycle in which the last word was accepted, and not earlier.
- R6: During a load phase, a word whose page field `addr[15:7]` differs from the phase's page is not stored. It sets `page_err`, which then stays 1 until reset.
- R7: Programming rewrites the whole page. Loaded words keep their data, every other word of the page reads back 16'hFFFF, and `busy` is high for exactly `PROG_CYC` cycles.
- R8: While `busy` is high, a read returns `BUSY_PATTERN` (default 16'hA5A5), and a write cycle is ignored. It neither changes the page nor starts a new load phase.
- R9: Outside programming, a read returns the word stored at `addr`. Pages are independent, and the page index is `addr[7+PIDX_W-1:7]`, so with four pages, page 4 aliases page 0.
- R10: Words of one page may be loaded in any order, and each lands at its own word index `addr[6:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | 16 | Word address: [15:7] page, [6:0] word in page |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, valid while `dout_en` is 1 |
| dout_en | output | 1 | Bus drive indication. 0 means high impedance |
| busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | Sticky flag: a word was dropped for a page mismatch |

## Verification
The assertions assume that the host holds every strobe level for at least `SYNC_STAGES`+1 clock cycles. They also assume that `addr` stays stable from the start of a strobe until the synchronised edge has been seen, and that `din` is held for a few cycles after the strobes are released. They further rely on `PROG_CYC` being at least the page size, so that the commit finishes inside the busy time. The stimulus keeps every strobe level for four or more cycles and holds data five cycles past deassertion. It changes address and data in the middle of a strobe only in the capture test, where the change comes well after the synchronised start edge and well before the end edge.

// File: rtl/pgp_pkg.sv
package pgp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_t;

endpackage

// File: rtl/pgp_strobe_sync.sv
module pgp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_start,
  output logic wr_end,
  output logic rd_act
);

  localparam int NSIG = 3;

  logic [NSIG-1:0] stage_q [STAGES];
  logic [NSIG-1:0] stage_d [STAGES];
  logic            ce_s, we_s, oe_s;
  logic            wr_act, wr_act_q;

  assign stage_d[0] = {oe_n, we_n, ce_n};

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_chain
      assign stage_d[g] = stage_q[g-1];
    end
    for (g = 0; g < STAGES; g++) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign ce_s = stage_q[STAGES-1][0];
  assign we_s = stage_q[STAGES-1][1];
  assign oe_s = stage_q[STAGES-1][2];

  assign wr_act = ~ce_s & ~we_s & oe_s;
  assign rd_act = ~ce_s & ~oe_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_act_q <= 1'b0;
    else        wr_act_q <= wr_act;
  end

  assign wr_start = wr_act & ~wr_act_q;
  assign wr_end   = ~wr_act & wr_act_q;

endmodule

// File: rtl/pgp_page_buf.sv
module pgp_page_buf #(
  parameter int WORDS  = 128,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [WORDS-1:0]  mask_q, mask_d;

  always_comb begin
    mask_d = clear ? '0 : mask_q;
    if (wr_en) mask_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_word = mask_q[rd_idx] ? mem_q[rd_idx] : {DATA_W{1'b1}};

endmodule

// File: rtl/pgp_store.sv
module pgp_store #(
  parameter int AW     = 9,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/pgp_page_prog.sv
module pgp_page_prog
  import pgp_pkg::*;
#(
  parameter int              ADDR_W       = 16,
  parameter int              DATA_W       = 16,
  parameter int              WORD_BITS    = 7,
  parameter int              NUM_PAGES    = 4,
  parameter int              LOAD_WIN_CYC = 200,
  parameter int              PROG_CYC     = 300,
  parameter int              SYNC_STAGES  = 2,
  parameter logic [DATA_W-1:0] BUSY_PATTERN = 16'hA5A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              page_err
);

  localparam int WORDS    = 1 << WORD_BITS;
  localparam int PAGE_W   = ADDR_W - WORD_BITS;
  localparam int PIDX_W   = $clog2(NUM_PAGES);
  localparam int STORE_AW = PIDX_W + WORD_BITS;
  localparam int TMR_W    = $clog2(LOAD_WIN_CYC + 1);
  localparam int PCNT_W   = $clog2(PROG_CYC + 1);
  localparam int PTR_W    = WORD_BITS + 1;
  localparam logic [TMR_W-1:0]  TMR_LOAD  = TMR_W'(LOAD_WIN_CYC - 1);
  localparam logic [PCNT_W-1:0] PCNT_LOAD = PCNT_W'(PROG_CYC - 1);
  localparam logic [PTR_W-1:0]  PTR_END   = PTR_W'(WORDS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  // strobe synchronisation and cycle edges
  logic wr_start, wr_end, rd_act;

  pgp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .wr_start (wr_start),
    .wr_end   (wr_end),
    .rd_act   (rd_act)
  );

  // address capture at the start of a write cycle
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_W-1:0] evt_page;
  logic [WORD_BITS-1:0] evt_word;

  assign addr_d   = wr_start ? addr : addr_q;
  assign evt_page = addr_q[ADDR_W-1:WORD_BITS];
  assign evt_word = addr_q[WORD_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) addr_q <= '0;
    else          addr_q <= addr_d;
  end

  // phase sequencer
  phase_t            phase_q, phase_d;
  logic [TMR_W-1:0]  timer_q, timer_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              err_q, err_d;
  logic              accept, buf_clear, arr_we;

  always_comb begin
    phase_d   = phase_q;
    timer_d   = timer_q;
    pcnt_d    = pcnt_q;
    ptr_d     = ptr_q;
    page_d    = page_q;
    err_d     = err_q;
    accept    = 1'b0;
    buf_clear = 1'b0;
    arr_we    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (wr_end) begin
          accept    = 1'b1;
          buf_clear = 1'b1;
          page_d    = evt_page;
          timer_d   = TMR_LOAD;
          phase_d   = PH_LOAD;
        end
      end
      PH_LOAD: begin
        if (wr_end && (evt_page == page_q)) begin
          accept  = 1'b1;
          timer_d = TMR_LOAD;
        end else begin
          if (wr_end) err_d = 1'b1;
          if (timer_q == '0) begin
            phase_d = PH_PROG;
            pcnt_d  = PCNT_LOAD;
            ptr_d   = '0;
          end else begin
            timer_d = timer_q - TMR_W'(1);
          end
        end
      end
      PH_PROG: begin
        if (ptr_q < PTR_END) begin
          arr_we = 1'b1;
          ptr_d  = ptr_q + PTR_W'(1);
        end
        if (pcnt_q == '0) phase_d = PH_IDLE;
        else              pcnt_d  = pcnt_q - PCNT_W'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q <= PH_IDLE;
      timer_q <= '0;
      pcnt_q  <= '0;
      ptr_q   <= '0;
      page_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      timer_q <= timer_d;
      pcnt_q  <= pcnt_d;
      ptr_q   <= ptr_d;
      page_q  <= page_d;
      err_q   <= err_d;
    end
  end

  // page buffer and storage array
  logic [DATA_W-1:0]   buf_word, arr_rdata;
  logic [STORE_AW-1:0] arr_waddr, arr_raddr;

  pgp_page_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .clear   (buf_clear),
    .wr_en   (accept),
    .wr_idx  (evt_word),
    .wr_data (din),
    .rd_idx  (ptr_q[WORD_BITS-1:0]),
    .rd_word (buf_word)
  );

  assign arr_waddr = {page_q[PIDX_W-1:0], ptr_q[WORD_BITS-1:0]};
  assign arr_raddr = addr[STORE_AW-1:0];

  pgp_store #(.AW(STORE_AW), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_en   (arr_we),
    .wr_addr (arr_waddr),
    .wr_data (buf_word),
    .rd_addr (arr_raddr),
    .rd_data (arr_rdata)
  );

  // read output register
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              den_q, den_d;

  assign busy   = (phase_q == PH_PROG);
  assign dout_d = busy ? BUSY_PATTERN : arr_rdata;
  assign den_d  = rd_act;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dout_q <= '0;
      den_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      den_q  <= den_d;
    end
  end

  assign dout     = dout_q;
  assign dout_en  = den_q;
  assign page_err = err_q;

endmodule

// File: rtl/pgp_page_prog_chk.sv
module pgp_page_prog_chk #(
  parameter int                DATA_W       = 16,
  parameter int                LOAD_WIN_CYC = 200,
  parameter int                PROG_CYC     = 300,
  parameter logic [DATA_W-1:0] BUSY_PATTERN = 16'hA5A5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              accept,
  input logic              rd_act,
  input logic              dout_en,
  input logic [DATA_W-1:0] dout,
  input logic              page_err
);

  localparam logic [31:0] GAP_MAX = 32'hFFFF_FFF0;

  logic [31:0] gap_q, len_q;

  // cycles since the last accepted word, and cycles spent busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GAP_MAX;
      len_q <= '0;
    end else begin
      gap_q <= accept ? '0 : ((gap_q < GAP_MAX) ? gap_q + 32'd1 : gap_q);
      len_q <= busy ? len_q + 32'd1 : '0;
    end
  end

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  assert_dout_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> $past(rd_act));

  assert_busy_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && $past(busy)) |-> (dout == BUSY_PATTERN));

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == 32'(PROG_CYC)));

  assert_load_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (gap_q == 32'(LOAD_WIN_CYC)));

endmodule

bind pgp_page_prog pgp_page_prog_chk #(
  .DATA_W       (DATA_W),
  .LOAD_WIN_CYC (LOAD_WIN_CYC),
  .PROG_CYC     (PROG_CYC),
  .BUSY_PATTERN (BUSY_PATTERN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_i),
  .busy     (busy),
  .accept   (accept),
  .rd_act   (rd_act),
  .dout_en  (dout_en),
  .dout     (dout),
  .page_err (page_err)
);

// File: tb/pgp_page_prog_test.sv
module pgp_page_prog_test;

  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 200;
  localparam int PROG = 300;
  localparam logic [15:0] STATUS = 16'hA5A5;

  // read-back table after the first page program: {addr, expected}
  localparam int NTAB = 7;
  localparam logic [31:0] TAB [NTAB] = '{
    {16'h00FF, 16'hBEEF},
    {16'h0085, 16'h1234},
    {16'h0080, 16'h0001},
    {16'h00C3, 16'h4242},
    {16'h0081, 16'hFFFF},
    {16'h0086, 16'hFFFF},
    {16'h00FE, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, we_n, oe_n;
  logic [15:0] addr, din;
  logic [15:0] dout;
  logic        dout_en, busy, page_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgp_page_prog uut (
    .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
    .addr (addr), .din (din), .dout (dout), .dout_en (dout_en),
    .busy (busy), .page_err (page_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(input logic [15:0] a, input logic [15:0] d,
                            input logic [15:0] a_late, input logic [15:0] d_early);
    @(negedge clk);
    addr = a; din = d_early; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    idle(6);
    addr = a_late; din = d;
    idle(4);
    we_n = 1'b1; ce_n = 1'b1;
    idle(5);
  endtask

  task automatic read_check(input logic [15:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    idle(5);
    check(dout_en === 1'b1 && dout === exp, tag, {15'd0, dout_en, dout}, {16'h0001, exp});
    ce_n = 1'b1; oe_n = 1'b1;
    idle(4);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(6);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    do_reset;

    // R1 reset state
    check(busy === 1'b0, "R1 busy after reset", {31'd0, busy}, 32'd0);
    check(page_err === 1'b0, "R1 page_err after reset", {31'd0, page_err}, 32'd0);
    check(dout_en === 1'b0, "R1 dout_en after reset", {31'd0, dout_en}, 32'd0);

    // R3 write strobes with oe_n low load nothing
    @(negedge clk);
    addr = 16'h0085; din = 16'h9999; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    idle(10);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    idle(WIN + 30);
    check(busy === 1'b0, "R3 no load with oe_n low", {31'd0, busy}, 32'd0);

    // R2 bus released unless both ce_n and oe_n are low
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; idle(5);
    check(dout_en === 1'b0, "R2 ce only", {31'd0, dout_en}, 32'd0);
    ce_n = 1'b1; oe_n = 1'b0; idle(5);
    check(dout_en === 1'b0, "R2 oe only", {31'd0, dout_en}, 32'd0);
    oe_n = 1'b1; idle(4);

    // load page 1 out of order (R10), then a foreign-page word (R6)
    write_word(16'h00FF, 16'hBEEF, 16'h00FF, 16'hBEEF);
    write_word(16'h0085, 16'h1234, 16'h0085, 16'h1234);
    write_word(16'h0080, 16'h0001, 16'h0080, 16'h0001);
    write_word(16'h0105, 16'hDEAD, 16'h0105, 16'hDEAD);
    check(page_err === 1'b1, "R6 page mismatch flagged", {31'd0, page_err}, 32'd1);
    idle(150);
    check(busy === 1'b0, "R5 still loading", {31'd0, busy}, 32'd0);
    write_word(16'h00C3, 16'h4242, 16'h00C3, 16'h4242);
    idle(150);
    check(busy === 1'b0, "R5 window restarted", {31'd0, busy}, 32'd0);
    idle(80);
    check(busy === 1'b1, "R5 window expired", {31'd0, busy}, 32'd1);

    // R8 status read and ignored write while busy
    read_check(16'h0085, STATUS, "R8 status while busy");
    write_word(16'h0086, 16'h5555, 16'h0086, 16'h5555);
    idle(PROG);
    check(busy === 1'b0, "R7 programming finished", {31'd0, busy}, 32'd0);
    idle(WIN + 30);
    check(busy === 1'b0, "R8 busy write started nothing", {31'd0, busy}, 32'd0);

    // R7 R9 R10 table walk over the programmed page
    for (int i = 0; i < NTAB; i++) begin
      read_check(TAB[i][31:16], TAB[i][15:0], "R7 R10 page readback");
    end
    check(page_err === 1'b1, "R6 flag sticky", {31'd0, page_err}, 32'd1);

    // R4 capture points: address at start, data at end
    write_word(16'h0081, 16'h7777, 16'h0090, 16'h1111);
    idle(WIN + PROG + 50);
    read_check(16'h0081, 16'h7777, "R4 address and data capture");
    read_check(16'h0090, 16'hFFFF, "R4 late address not used");
    read_check(16'h0085, 16'hFFFF, "R7 unloaded word erased");
    read_check(16'h00FF, 16'hFFFF, "R7 whole page rewritten");

    // R9 independent pages and aliasing
    write_word(16'h0010, 16'h0BAD, 16'h0010, 16'h0BAD);
    idle(WIN + PROG + 50);
    read_check(16'h0010, 16'h0BAD, "R9 page 0 word");
    read_check(16'h0081, 16'h7777, "R9 page 1 untouched");
    read_check(16'h0210, 16'h0BAD, "R9 page 4 aliases page 0");

    // R1 reset clears the sticky flag
    do_reset;
    check(page_err === 1'b0, "R1 page_err cleared by reset", {31'd0, page_err}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule